// File: doc/BRIEF.md
# Tightly Coupled Instruction Memory Slave

This block is a single-port synchronous RAM that sits on a processor's instruction tightly coupled memory port. The core presents a 20-bit word address, 32-bit write data, a select, a direction flag and four byte-lane write strobes. The slave returns read data one cycle after it accepts a read, plus an error flag that travels with that data. A DMA requester shares the same RAM array. The DMA port always wins. Its request is registered, and the slave raises a wait signal to the core one cycle before the DMA access takes the array. The core must keep its request on the port until it sees wait low.

The array holds 2^DEPTH_LOG2 words. Only the low DEPTH_LOG2 word-address bits are used, so accesses beyond the capacity wrap. A constant 5-bit output reports the capacity on a logarithmic scale. The scale is: 0 means no memory, and code k (k = 1..13) means 2^(k-1) KB.

Top module: `itcm_slave`

## Requirements
- R1: While and right after reset (rst high at a clock edge), core_wait, core_err and dma_rvalid are 0 and core_rdata is 0.
- R2: size_code equals DEPTH_LOG2 - 7. This is the code k for a capacity of 2^(k-1) KB, given 4-byte words; for example, DEPTH_LOG2 = 8 (1 KB) gives 1.
- R3: A core write is accepted at an edge where core_cs = 1, core_write = 1 and core_wait is low. It replaces byte lane i (bits 8i+7..8i) of the addressed word for each set bit i of core_be, and leaves the other lanes unchanged. Bit 0 is the least significant byte, so 4'b0011 writes the lower half-word.
- R4: A core write with core_be = 4'b0000 leaves the memory unchanged.
- R5: A core read (core_write = 0) never writes the array, even with a nonzero core_be. core_err is 1 alongside the returned data exactly when that read carried a nonzero core_be, and 0 for a clean read.
- R6: A core read accepted at an edge (core_cs = 1, core_write = 0, core_wait low) drives the addressed word on core_rdata right after that edge. core_rdata and core_err then hold until the next accepted core read, and in particular do not change at any edge where core_wait was high.
- R7: dma_req sampled high at an edge drives core_wait high for the next cycle. dma_req sampled low drives core_wait low for the next cycle.
- R8: A core request sampled at an edge where core_wait is high is not performed: it neither writes the array nor changes core_rdata.
- R9: Only the low DEPTH_LOG2 bits of a word address are used, so address a + 2^DEPTH_LOG2 reaches the same word as a.
- R10: A DMA request sampled at edge e accesses the array at edge e+1, with byte-lane writes governed by dma_be as in R3 when dma_write = 1. A DMA read raises dma_rvalid right after e+1, with the addressed word on dma_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_addr | input | 20 | Core word address |
| core_wdata | input | 32 | Core write data |
| core_cs | input | 1 | Core request select |
| core_write | input | 1 | 1 = write, 0 = read |
| core_be | input | 4 | Core byte-lane write strobes |
| core_rdata | output | 32 | Core read data |
| core_wait | output | 1 | Next edge will not serve the core |
| core_err | output | 1 | Error flag accompanying core read data |
| size_code | output | 5 | Logarithmic capacity code |
| dma_req | input | 1 | DMA request |
| dma_write | input | 1 | DMA direction, 1 = write |
| dma_addr | input | 20 | DMA word address |
| dma_wdata | input | 32 | DMA write data |
| dma_be | input | 4 | DMA byte-lane write strobes |
| dma_rdata | output | 32 | DMA read data |
| dma_rvalid | output | 1 | DMA read data valid |

## Verification
The assertions check on every cycle that wait follows the registered DMA request one cycle later and drops when the request stops. They also check that core read data stays frozen across any edge where wait was high, that the error flag only rises after an accepted core read, and that DMA read data only appears after a cycle in which wait was high. Which bytes a write actually changes, the effect of all-zero strobes, address wrap and the size code can only be shown by the bench. It does this with an exhaustive strobe sweep, a full fill and readback of a 1 KB array, and scripted DMA conflicts.

// File: rtl/itcm_pkg.sv
package itcm_pkg;
  localparam int ADDR_W = 20;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // One array operation per cycle, chosen by the arbiter
  typedef struct packed {
    logic              en;
    logic [LANES-1:0]  we;
    logic [DATA_W-1:0] wdata;
  } lane_op_t;

  // Capacity code: 2^(k-1) KB for code k, 4-byte words
  function automatic logic [4:0] size_code_f(input int depth_log2);
    if (depth_log2 < 8) return 5'd0;
    return 5'(depth_log2 - 7);
  endfunction
endpackage

// File: rtl/itcm_arb.sv
module itcm_arb
  import itcm_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     core_addr,
  input  logic [DATA_W-1:0]     core_wdata,
  input  logic                  core_cs,
  input  logic                  core_write,
  input  logic [LANES-1:0]      core_be,
  input  logic                  dma_req,
  input  logic                  dma_write,
  input  logic [ADDR_W-1:0]     dma_addr,
  input  logic [DATA_W-1:0]     dma_wdata,
  input  logic [LANES-1:0]      dma_be,
  output lane_op_t              op,
  output logic [DEPTH_LOG2-1:0] op_addr,
  output logic                  stall,
  output logic                  core_rd_fire,
  output logic                  core_bad_be,
  output logic                  dma_rd_fire
);
  logic                  slot_q;
  logic                  dwr_q;
  logic [DEPTH_LOG2-1:0] daddr_q;
  logic [DATA_W-1:0]     dwd_q;
  logic [LANES-1:0]      dbe_q;

  // DMA request is captured one edge ahead of its array access
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= 1'b0;
    end else begin
      slot_q <= dma_req;
    end
    if (dma_req) begin
      dwr_q   <= dma_write;
      daddr_q <= dma_addr[DEPTH_LOG2-1:0];
      dwd_q   <= dma_wdata;
      dbe_q   <= dma_be;
    end
  end

  assign stall = slot_q;

  always_comb begin
    op      = '0;
    op_addr = core_addr[DEPTH_LOG2-1:0];
    if (slot_q) begin
      op.en    = 1'b1;
      op.we    = dwr_q ? dbe_q : '0;
      op.wdata = dwd_q;
      op_addr  = daddr_q;
    end else if (core_cs) begin
      op.en    = 1'b1;
      op.we    = core_write ? core_be : '0;
      op.wdata = core_wdata;
    end
  end

  assign core_rd_fire = !slot_q && core_cs && !core_write;
  assign core_bad_be  = |core_be;
  assign dma_rd_fire  = slot_q && !dwr_q;

  generate
    if (DEPTH_LOG2 < ADDR_W) begin : g_wrap
      logic unused_hi;
      assign unused_hi = ^{core_addr[ADDR_W-1:DEPTH_LOG2], dma_addr[ADDR_W-1:DEPTH_LOG2]};
    end
  endgenerate
endmodule

// File: rtl/itcm_bank.sv
module itcm_bank
  import itcm_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  lane_op_t              op,
  input  logic [DEPTH_LOG2-1:0] op_addr,
  output logic [DATA_W-1:0]     q
);
  localparam int WORDS = 1 << DEPTH_LOG2;

  // One narrow array per byte lane so each maps onto block RAM
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [WORDS];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (op.en) begin
          if (op.we[i]) mem[op_addr] <= op.wdata[i*LANE_W +: LANE_W];
          rd_q <= mem[op_addr];
        end
      end

      assign q[i*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/itcm_ret.sv
module itcm_ret
  import itcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              core_rd_fire,
  input  logic              core_bad_be,
  input  logic              dma_rd_fire,
  input  logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_err,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_rvalid
);
  logic              core_sel_q;
  logic [DATA_W-1:0] hold_q;
  logic              err_q;
  logic              dv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_sel_q <= 1'b0;
      hold_q     <= '0;
      err_q      <= 1'b0;
      dv_q       <= 1'b0;
    end else begin
      core_sel_q <= core_rd_fire;
      hold_q     <= core_rdata;
      dv_q       <= dma_rd_fire;
      if (core_rd_fire) err_q <= core_bad_be;
    end
  end

  // Fresh RAM word right after a core read, otherwise the held copy
  assign core_rdata = core_sel_q ? q : hold_q;
  assign core_err   = err_q;
  assign dma_rdata  = dv_q ? q : '0;
  assign dma_rvalid = dv_q;
endmodule

// File: rtl/itcm_slave.sv
module itcm_slave
  import itcm_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] core_addr,
  input  logic [31:0] core_wdata,
  input  logic        core_cs,
  input  logic        core_write,
  input  logic [3:0]  core_be,
  output logic [31:0] core_rdata,
  output logic        core_wait,
  output logic        core_err,
  output logic [4:0]  size_code,
  input  logic        dma_req,
  input  logic        dma_write,
  input  logic [19:0] dma_addr,
  input  logic [31:0] dma_wdata,
  input  logic [3:0]  dma_be,
  output logic [31:0] dma_rdata,
  output logic        dma_rvalid
);
  lane_op_t              op;
  logic [DEPTH_LOG2-1:0] op_addr;
  logic [DATA_W-1:0]     q;
  logic                  core_rd_fire;
  logic                  core_bad_be;
  logic                  dma_rd_fire;

  itcm_arb #(.DEPTH_LOG2(DEPTH_LOG2)) u_arb (
    .clk(clk), .rst(rst),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_cs(core_cs),
    .core_write(core_write), .core_be(core_be),
    .dma_req(dma_req), .dma_write(dma_write), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_be(dma_be),
    .op(op), .op_addr(op_addr), .stall(core_wait),
    .core_rd_fire(core_rd_fire), .core_bad_be(core_bad_be),
    .dma_rd_fire(dma_rd_fire)
  );

  itcm_bank #(.DEPTH_LOG2(DEPTH_LOG2)) u_bank (
    .clk(clk), .op(op), .op_addr(op_addr), .q(q)
  );

  itcm_ret u_ret (
    .clk(clk), .rst(rst),
    .core_rd_fire(core_rd_fire), .core_bad_be(core_bad_be),
    .dma_rd_fire(dma_rd_fire), .q(q),
    .core_rdata(core_rdata), .core_err(core_err),
    .dma_rdata(dma_rdata), .dma_rvalid(dma_rvalid)
  );

  assign size_code = size_code_f(DEPTH_LOG2);
endmodule

// File: rtl/itcm_slave_chk.sv
module itcm_slave_chk (
  input logic        clk,
  input logic        rst,
  input logic        core_cs,
  input logic        core_write,
  input logic        core_wait,
  input logic [31:0] core_rdata,
  input logic        core_err,
  input logic        dma_req,
  input logic        dma_rvalid
);
  p_wait_ahead_r7: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> core_wait);

  p_wait_release_r7: assert property (@(posedge clk) disable iff (rst)
    !dma_req |=> !core_wait);

  p_rdata_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    core_wait |=> $stable(core_rdata) && $stable(core_err));

  p_err_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_err) |-> $past(core_cs && !core_write && !core_wait));

  p_dma_data_slot_r10: assert property (@(posedge clk) disable iff (rst)
    dma_rvalid |-> $past(core_wait));
endmodule

bind itcm_slave itcm_slave_chk u_chk (.*);

// File: tb/itcm_slave_test.sv
module itcm_slave_test;
  localparam int DL = 8;
  localparam int WORDS = 1 << DL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic        core_cs = 1'b0;
  logic        core_write = 1'b0;
  logic [3:0]  core_be = '0;
  logic [31:0] core_rdata;
  logic        core_wait;
  logic        core_err;
  logic [4:0]  size_code;
  logic        dma_req = 1'b0;
  logic        dma_write = 1'b0;
  logic [19:0] dma_addr = '0;
  logic [31:0] dma_wdata = '0;
  logic [3:0]  dma_be = '0;
  logic [31:0] dma_rdata;
  logic        dma_rvalid;

  int total = 0;
  int bad = 0;
  logic [31:0] model [WORDS];

  itcm_slave #(.DEPTH_LOG2(DL)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  // Drives one core request just after a falling edge, returns after the next one
  task automatic core_op(input logic wr, input logic [3:0] be, input logic [19:0] a,
                         input logic [31:0] d);
    core_cs = 1'b1; core_write = wr; core_be = be; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_cs = 1'b0; core_write = 1'b0; core_be = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wait", 32'(core_wait), 0);
    chk("R1 err", 32'(core_err), 0);
    chk("R1 dvalid", 32'(dma_rvalid), 0);
    chk("R1 rdata", core_rdata, 0);
    chk("R2 size", 32'(size_code), 32'($clog2((4 * WORDS) / 1024) + 1));
    rst = 1'b0;
    @(negedge clk);

    // Fill and read back the whole array
    for (int a = 0; a < WORDS; a++) begin
      model[a] = (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F1E;
      core_op(1'b1, 4'hF, 20'(a), model[a]);
    end
    for (int a = 0; a < WORDS; a++) begin
      core_op(1'b0, 4'h0, 20'(a), 0);
      chk("R3 fill readback", core_rdata, model[a]);
    end

    // Every strobe pattern on several words; 0000 covers R4
    for (int a = 0; a < 16; a++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d = 32'h1357_9BDF ^ (32'(a) << 8) ^ (32'(be) * 32'h1111_0000);
        core_op(1'b1, 4'(be), 20'(a), d);
        model[a] = merge(model[a], d, 4'(be));
        core_op(1'b0, 4'h0, 20'(a), 0);
        if (be == 0) chk("R4 zero strobes", core_rdata, model[a]);
        else chk("R3 lane write", core_rdata, model[a]);
      end
    end

    // Read with strobes set: flagged, and nothing written
    core_wdata = 32'hFFFF_FFFF;
    core_op(1'b0, 4'h5, 20'd3, 32'hFFFF_FFFF);
    chk("R5 err on bad read", 32'(core_err), 1);
    chk("R5 data on bad read", core_rdata, model[3]);
    core_op(1'b0, 4'h0, 20'd3, 0);
    chk("R5 err clean read", 32'(core_err), 0);
    chk("R5 no write", core_rdata, model[3]);

    // Address wrap
    core_op(1'b1, 4'hF, 20'(9 + 3 * WORDS), 32'hC0DE_0009);
    model[9] = 32'hC0DE_0009;
    core_op(1'b0, 4'h0, 20'd9, 0);
    chk("R9 wrap write", core_rdata, model[9]);
    core_op(1'b0, 4'h0, 20'(33 + WORDS), 0);
    chk("R9 wrap read", core_rdata, model[33]);

    // Conflict: DMA read against a core read, then an ignored core write
    dma_req = 1'b1; dma_write = 1'b0; dma_addr = 20'd20;
    core_cs = 1'b1; core_write = 1'b0; core_be = '0; core_addr = 20'd21;
    @(negedge clk);
    chk("R7 wait raised", 32'(core_wait), 1);
    chk("R6 core read before slot", core_rdata, model[21]);
    dma_req = 1'b0;
    core_write = 1'b1; core_be = 4'hF; core_addr = 20'd22; core_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    core_cs = 1'b0; core_write = 1'b0; core_be = '0;
    chk("R7 wait dropped", 32'(core_wait), 0);
    chk("R10 dma rvalid", 32'(dma_rvalid), 1);
    chk("R10 dma rdata", dma_rdata, model[20]);
    chk("R6 rdata held", core_rdata, model[21]);
    core_op(1'b0, 4'h0, 20'd22, 0);
    chk("R8 stalled write dropped", core_rdata, model[22]);

    // DMA partial write
    dma_req = 1'b1; dma_write = 1'b1; dma_addr = 20'd30; dma_be = 4'b0110;
    dma_wdata = 32'h1122_3344;
    @(negedge clk);
    dma_req = 1'b0; dma_write = 1'b0; dma_be = '0;
    @(negedge clk);
    chk("R10 no rvalid on write", 32'(dma_rvalid), 0);
    model[30] = merge(model[30], 32'h1122_3344, 4'b0110);
    core_op(1'b0, 4'h0, 20'd30, 0);
    chk("R10 dma lane write", core_rdata, model[30]);

    // Back-to-back DMA reads with a core read held across the stall
    dma_req = 1'b1; dma_addr = 20'd40;
    @(negedge clk);
    chk("R7 wait burst 1", 32'(core_wait), 1);
    core_cs = 1'b1; core_write = 1'b0; core_addr = 20'd50;
    dma_addr = 20'd41;
    @(negedge clk);
    chk("R7 wait burst 2", 32'(core_wait), 1);
    chk("R10 burst data 40", dma_rdata, model[40]);
    chk("R8 core read stalled", core_rdata, model[30]);
    dma_addr = 20'd42;
    @(negedge clk);
    chk("R7 wait burst 3", 32'(core_wait), 1);
    chk("R10 burst data 41", dma_rdata, model[41]);
    chk("R6 held during wait", core_rdata, model[30]);
    dma_req = 1'b0;
    @(negedge clk);
    chk("R7 wait end", 32'(core_wait), 0);
    chk("R10 burst data 42", dma_rdata, model[42]);
    chk("R6 held last slot", core_rdata, model[30]);
    @(negedge clk);
    core_cs = 1'b0;
    chk("R6 held read served", core_rdata, model[50]);
    chk("R10 rvalid clears", 32'(dma_rvalid), 0);

    // Reset again
    rst = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", core_rdata, 0);
    chk("R1 wait after reset", 32'(core_wait), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule